// File: doc/BRIEF.md
# GPIO Output Driver with Masked Write

This block holds the output-side state of a general-purpose I/O port with `NPIN` lines (32 by default) and drives the value and enable lines for each pad. The stored state covers five things. The first is the output data word. The second is a per-pin driver enable. The third is a per-pin open-drain enable. The fourth is a per-pin ownership bit, which decides whether the GPIO logic or a peripheral controls the pad. The last is a two-bit select per pin that picks one of four peripheral sources.

The output data can change in three ways. Set and clear masks change individual bits. A direct word write changes only the bits that a write-enable mask allows. Every configuration mask is changed through a single command port. That port carries a 4-bit operation code and a pin mask, and each operation turns bits on or off in one of the masks. A bus decoder in front of the block turns register accesses into these strobes. The pad signals are combinational from the stored state.

Top module: `gpio_out_ctrl`

## Requirements
- R1: After reset, all pins are owned by the GPIO logic, `pad_oe` is all zeros, `odata` is zero, and `od_mask` is zero. Because the pins are GPIO-owned, `pad_out` is zero whatever the peripheral inputs carry.
- R2: On a cycle with `set_stb`, each 1 in `set_mask` makes that `odata` bit 1 after the clock edge. On a cycle with `clr_stb`, each 1 in `clr_mask` makes that bit 0. All other bits keep their value.
- R3: When operations meet in the same cycle, clear has the highest priority, set comes next, and the direct write comes last. A bit that is both set and cleared ends at 0. A set or clear bit overrides the direct write on that bit.
- R4: A direct write (`wr_stb`, `wr_data`) updates only the `odata` bits whose write-enable bit is 1. The command codes for the write-enable mask are 6 (enable the masked pins) and 7 (disable them). Write-enable resets to all zeros.
- R5: The output data is stored even while a pin's driver is off. Once the pin is enabled with code 0, the stored value appears on `pad_out` and `pad_oe` rises. Code 1 disables the driver.
- R6: Open-drain is enabled with code 4 and disabled with code 5, and its mask is visible on `od_mask`. On a GPIO-owned pin in open-drain mode, `pad_oe` is 1 only when the driver is enabled and `odata` is 0.
- R7: Code 3 releases ownership of a pin and code 2 takes it back. A released pin drives `pad_out` and `pad_oe` from the selected peripheral: select 00 picks A, 01 picks B, 10 picks C and 11 picks D. Codes 8 and 9 set and clear the select's low bit, and codes 10 and 11 set and clear its high bit.
- R8: Command codes 12 to 15 change no state.
- R9: Every strobe takes effect at the clock edge that samples it, and the pads show the new state right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_stb | input | 1 | Apply the set mask |
| set_mask | input | NPIN | Bits of `odata` to drive to 1 |
| clr_stb | input | 1 | Apply the clear mask |
| clr_mask | input | NPIN | Bits of `odata` to drive to 0 |
| wr_stb | input | 1 | Direct write of `odata` through the write-enable mask |
| wr_data | input | NPIN | Data for the direct write |
| cfg_stb | input | 1 | Execute a command |
| cfg_op | input | 4 | Command code |
| cfg_mask | input | NPIN | Pins the command acts on |
| periph_out | input | 4 x NPIN | Peripheral output values, index 0..3 = A..D |
| periph_oe | input | 4 x NPIN | Peripheral output enables, index 0..3 = A..D |
| pad_out | output | NPIN | Value driven to each pad |
| pad_oe | output | NPIN | Driver enable for each pad |
| odata | output | NPIN | Stored output data |
| od_mask | output | NPIN | Open-drain enable mask |

## Verification
The set path and the clear path can act on the same bit in one cycle. The direct write can also arrive in that cycle. The bench drives several of these strobes together at one falling edge, with masks that overlap on some bits and not on others. After the next rising edge it compares every `odata` bit with the fixed priority: clear first, then set, then the write. A second case combines a set with a write whose data is zero on write-enabled bits. Here the set bit must survive while the neighbouring write-enabled bits fall.

// File: rtl/gpio_out_ctrl.sv
module gpio_out_ctrl #(
  parameter int NPIN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_stb,
  input  logic [NPIN-1:0]      set_mask,
  input  logic                 clr_stb,
  input  logic [NPIN-1:0]      clr_mask,
  input  logic                 wr_stb,
  input  logic [NPIN-1:0]      wr_data,
  input  logic                 cfg_stb,
  input  logic [3:0]           cfg_op,
  input  logic [NPIN-1:0]      cfg_mask,
  input  logic [3:0][NPIN-1:0] periph_out,
  input  logic [3:0][NPIN-1:0] periph_oe,
  output logic [NPIN-1:0]      pad_out,
  output logic [NPIN-1:0]      pad_oe,
  output logic [NPIN-1:0]      odata,
  output logic [NPIN-1:0]      od_mask
);
  localparam logic [3:0] OP_OE_ON    = 4'd0;
  localparam logic [3:0] OP_OE_OFF   = 4'd1;
  localparam logic [3:0] OP_OWN_ON   = 4'd2;
  localparam logic [3:0] OP_OWN_OFF  = 4'd3;
  localparam logic [3:0] OP_OD_ON    = 4'd4;
  localparam logic [3:0] OP_OD_OFF   = 4'd5;
  localparam logic [3:0] OP_WE_ON    = 4'd6;
  localparam logic [3:0] OP_WE_OFF   = 4'd7;
  localparam logic [3:0] OP_SEL0_SET = 4'd8;
  localparam logic [3:0] OP_SEL0_CLR = 4'd9;
  localparam logic [3:0] OP_SEL1_SET = 4'd10;
  localparam logic [3:0] OP_SEL1_CLR = 4'd11;

  logic [NPIN-1:0] odata_q, oe_q, own_q, od_q, we_q, sel0_q, sel1_q;
  logic [NPIN-1:0] set_eff, clr_eff, wr_eff;

  assign set_eff = set_stb ? set_mask : '0;
  assign clr_eff = clr_stb ? clr_mask : '0;
  assign wr_eff  = wr_stb  ? we_q     : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) odata_q <= '0;
    else        odata_q <= (((odata_q & ~wr_eff) | (wr_data & wr_eff)) | set_eff) & ~clr_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= '0;
      own_q  <= '1;
      od_q   <= '0;
      we_q   <= '0;
      sel0_q <= '0;
      sel1_q <= '0;
    end else if (cfg_stb) begin
      case (cfg_op)
        OP_OE_ON:    oe_q   <= oe_q   |  cfg_mask;
        OP_OE_OFF:   oe_q   <= oe_q   & ~cfg_mask;
        OP_OWN_ON:   own_q  <= own_q  |  cfg_mask;
        OP_OWN_OFF:  own_q  <= own_q  & ~cfg_mask;
        OP_OD_ON:    od_q   <= od_q   |  cfg_mask;
        OP_OD_OFF:   od_q   <= od_q   & ~cfg_mask;
        OP_WE_ON:    we_q   <= we_q   |  cfg_mask;
        OP_WE_OFF:   we_q   <= we_q   & ~cfg_mask;
        OP_SEL0_SET: sel0_q <= sel0_q |  cfg_mask;
        OP_SEL0_CLR: sel0_q <= sel0_q & ~cfg_mask;
        OP_SEL1_SET: sel1_q <= sel1_q |  cfg_mask;
        OP_SEL1_CLR: sel1_q <= sel1_q & ~cfg_mask;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [1:0] sel;
    logic       gp_oe;
    assign sel       = {sel1_q[i], sel0_q[i]};
    assign gp_oe     = oe_q[i] & ~(od_q[i] & odata_q[i]);
    assign pad_out[i] = own_q[i] ? odata_q[i] : periph_out[sel][i];
    assign pad_oe[i]  = own_q[i] ? gp_oe      : periph_oe[sel][i];
  end

  assign odata   = odata_q;
  assign od_mask = od_q;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((odata_q & $past(set_mask & ~(clr_stb ? clr_mask : '0))) == $past(set_mask & ~(clr_stb ? clr_mask : '0)))); // R2
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((odata_q & $past(clr_mask)) == '0)); // R3
  AST_WE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> (((odata_q ^ $past(odata_q)) & ~($past(wr_stb) ? $past(we_q) : '0)) == '0)); // R4
  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & own_q & od_q & odata_q) == '0)); // R6
  AST_BAD_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stb && cfg_op >= 4'd12) |=> ($stable(oe_q) && $stable(own_q) && $stable(od_q) && $stable(we_q))); // R8
endmodule

// File: tb/tb_gpio_out_ctrl.sv
module tb_gpio_out_ctrl;
  localparam int N = 32;
  logic clk = 0, rst_n = 0;
  logic set_stb = 0, clr_stb = 0, wr_stb = 0, cfg_stb = 0;
  logic [N-1:0] set_mask = '0, clr_mask = '0, wr_data = '0, cfg_mask = '0;
  logic [3:0] cfg_op = '0;
  logic [3:0][N-1:0] periph_out, periph_oe;
  logic [N-1:0] pad_out, pad_oe, odata, od_mask;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  gpio_out_ctrl #(.NPIN(N)) dut (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .set_mask(set_mask),
    .clr_stb(clr_stb), .clr_mask(clr_mask), .wr_stb(wr_stb), .wr_data(wr_data),
    .cfg_stb(cfg_stb), .cfg_op(cfg_op), .cfg_mask(cfg_mask),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .odata(odata), .od_mask(od_mask));

  typedef struct packed {
    logic [N-1:0] s, c, w;
    logic         ws;
    logic [N-1:0] exp;
    logic [7:0]   req;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h000000F0, 32'h0,        32'h0,        1'b0, 32'h000000F0, 8'd2}, // R2 set
    '{32'h0,        32'h00000030, 32'h0,        1'b0, 32'h000000C0, 8'd2}, // R2 clear
    '{32'h0,        32'h0,        32'hFFFF1234, 1'b1, 32'h00001234, 8'd4}, // R4 masked write
    '{32'h0F000000, 32'h0F000000, 32'h0,        1'b0, 32'h00001234, 8'd3}, // R3 clear beats set
    '{32'h00000001, 32'h00000002, 32'h0,        1'b1, 32'h00000001, 8'd3}, // R3 set/clear beat write
    '{32'hA0000000, 32'h0,        32'h0,        1'b0, 32'hA0000001, 8'd2}, // R2
    '{32'h0,        32'h0,        32'hFFFFFFFF, 1'b1, 32'hA000FFFF, 8'd4}, // R4
    '{32'h80000000, 32'hFFFFFFFF, 32'h0,        1'b0, 32'h00000000, 8'd3}  // R3
  };

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [3:0] op, logic [N-1:0] m);
    @(negedge clk); cfg_stb = 1; cfg_op = op; cfg_mask = m;
    @(negedge clk); cfg_stb = 0; cfg_mask = '0;
  endtask

  task automatic data(logic [N-1:0] s, logic [N-1:0] c, logic ws, logic [N-1:0] w);
    @(negedge clk);
    set_stb = (s != '0); set_mask = s;
    clr_stb = (c != '0); clr_mask = c;
    wr_stb = ws; wr_data = w;
    @(negedge clk);
    set_stb = 0; clr_stb = 0; wr_stb = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] po, pe, pm;
    periph_out[0] = 32'h11111111; periph_oe[0] = 32'h0000000F;
    periph_out[1] = 32'h22222222; periph_oe[1] = 32'h000000F0;
    periph_out[2] = 32'h44444444; periph_oe[2] = 32'h00000F00;
    periph_out[3] = 32'h88888888; periph_oe[3] = 32'h0000F000;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_out", pad_out, '0);
    check("R1 odata", odata, '0);
    check("R1 od_mask", od_mask, '0);
    rst_n = 1;
    cfg(4'd6, 32'h0000FFFF); // R4 write-enable low half

    for (int k = 0; k < 8; k++) begin
      data(VECS[k].s, VECS[k].c, VECS[k].ws, VECS[k].w);
      tests++;
      if (odata !== VECS[k].exp) begin
        fails++;
        $display("FAIL R%0d vec %0d: actual %h expected %h", VECS[k].req, k, odata, VECS[k].exp);
      end
    end

    // R5 stored while driver off
    data(32'h00FF0000, '0, 1'b0, '0);
    check("R5 oe off", pad_oe, '0);
    cfg(4'd0, 32'h00FF0000);
    check("R5 oe on", pad_oe, 32'h00FF0000);
    check("R5 value", pad_out & 32'h00FF0000, 32'h00FF0000);

    // R6 open drain
    cfg(4'd4, 32'h00030000);
    check("R6 mask", od_mask, 32'h00030000);
    check("R6 release", pad_oe, 32'h00FC0000);
    data('0, 32'h00010000, 1'b0, '0);
    check("R6 pull low", pad_oe, 32'h00FD0000);

    // R7 peripheral select
    cfg(4'd3, 32'h0000000F);
    check("R7 sel A out", pad_out & 32'hFF, 32'h01);
    check("R7 sel A oe", pad_oe & 32'hFF, 32'h0F);
    cfg(4'd8, 32'h00000002);
    check("R7 sel B out", pad_out & 32'hFF, 32'h03);
    check("R7 sel B oe", pad_oe & 32'hFF, 32'h0D);
    cfg(4'd10, 32'h0000000C);
    cfg(4'd8, 32'h00000008);
    check("R7 sel C/D out", pad_out & 32'hFF, 32'h0F);
    check("R7 sel C/D oe", pad_oe & 32'hFF, 32'h01);

    // R8 undefined codes
    po = pad_out; pe = pad_oe; pm = od_mask;
    for (int op = 12; op < 16; op++) begin
      cfg(op[3:0], '1);
      check("R8 pad_out", pad_out, po);
      check("R8 pad_oe", pad_oe, pe);
      check("R8 od_mask", od_mask, pm);
    end

    cfg(4'd2, 32'h0000000F);
    check("R7 reclaim", pad_oe & 32'hF, 32'h0);

    // R4 write-enable off blocks writes
    cfg(4'd7, '1);
    po = odata;
    data('0, '0, 1'b1, 32'hFFFFFFFF);
    check("R4 we off", odata, po);

    // R5 driver disable, R9 visible right after edge
    cfg(4'd1, 32'h00FF0000);
    check("R5/R9 oe off", pad_oe, '0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule